// File: doc/BRIEF.md
# Generic SPI Slave Command Interface

This block is the device end of a four-wire serial command link. A host frames every transaction with an active-low chip select, shifts in a 32-bit command word MSB first on the rising edge of the serial clock, and then either sends data words (write) or receives them (read). The block oversamples the serial lines with its own system clock, decodes each command, and serves function 0 from a small local register set: bus configuration, status-append control, a 16-bit interrupt register with its enable, a fixed link signature and a scratch test register.

Commands for functions 1, 2 and 3 are not served locally. Each data word of such a transaction appears as a one-cycle request carrying function, address, byte length and write data; read data is taken from the request port in that same cycle. After the data phase the block can append a 32-bit status word built from device flags, so the host learns FIFO state without a separate read.

The link starts in a 16-bit word mode in which every 32-bit word crosses the wire with its two halfwords exchanged; the host switches to plain 32-bit words by setting the word-length bit of the bus configuration register.

Top module: `gspi_slave`

## Requirements
- R1: A command word carries write(1)/read(0) in bit 31, increment(1)/fixed(0) in bit 30, the function number in bits 29:28, a 17-bit address in bits 27:11 and a byte length in bits 10:0.
- R2: While bus configuration bit 0 is 0 (the reset value) every word on the wire, command, data and status, is the logical word rotated by 16; when it is 1 words cross unrotated. A change applies from the next transaction.
- R3: Function-0 byte 0x00 is bus configuration (reset 0x30; writable bits 0, 1, 4, 5, 7) and byte 0x02 is status control (reset 0x01; writable bits 0, 1); bytes 0x01 and 0x03 read 0, so a 4-byte read at 0x00 after reset returns 0x00010030.
- R4: Function-0 bytes 0x14..0x17 always read 0xFEEDBEAD (little-endian bytes) and ignore writes.
- R5: Function-0 bytes 0x18..0x1B form a read/write test register.
- R6: Byte k of a data word (bits 8k+7:8k) maps to address A+k when increment is set; with increment clear every byte maps to A, and on a write the highest enabled byte wins.
- R7: A transaction carries ceil(length/4) data words; on a function-0 write only the first length bytes are stored.
- R8: When status control bit 0 is set at command time, a status word follows the data phase; its bits 0, 1, 2, 3, 5 and 8 copy the device flags, all other bits read 0. When clear, the wire stays 0 in that slot.
- R9: Interrupt bits (byte 0x04 low, byte 0x05 high) are set by source pulses, cleared by writing 1, and a set in the same cycle as a clear wins; bytes 0x06/0x07 hold the enables.
- R10: The interrupt output is asserted whenever an enabled interrupt bit is pending, active high when bus configuration bit 5 is 1 and active low when it is 0.
- R11: Chip select rising before a data word is complete aborts the transaction and commits nothing from that word.
- R12: Functions 1..3 issue one request per data word with the command's function and length; the address starts at the command address and advances by 4 per word only when increment is set; function 0 never appears on the request port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial link |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_mosi | input | 1 | Serial data from the host |
| spi_cs_n | input | 1 | Active-low chip select framing a transaction |
| spi_miso | output | 1 | Serial data to the host, changes after falling edges |
| irq | output | 1 | Interrupt to the host, polarity programmable |
| int_src | input | 16 | One-cycle pulses that set interrupt bits |
| dev_status | input | 9 | Device flags reported in the status word |
| req_valid | output | 1 | One-cycle request for a function 1..3 word |
| req_write | output | 1 | Request is a write |
| req_func | output | 2 | Function number of the request |
| req_addr | output | 17 | Address of the request word |
| req_len | output | 11 | Byte length of the whole transaction |
| req_wdata | output | 32 | Write data (logical word) |
| req_rdata | input | 32 | Read data, valid in the cycle of a read request |

## Verification
The bench builds the block with its default two-stage line synchronizer and a serial clock of sixteen system clocks, slow enough that every falling-edge update of the output is settled before the host samples, so each word is checked bit-exact through the real wire protocol. It runs in both word modes, switching mid-run through the configuration register, which exercises the rotation of command, data and status words and the rule that the mode is latched per transaction. A combinational responder on the request port makes multi-word read and write bursts on functions 1 to 3 observable, with both incrementing and fixed addresses.

// File: rtl/gspi_pkg.sv
package gspi_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned ADDR_W = 17;
    localparam int unsigned LEN_W  = 11;
    localparam int unsigned INT_W  = 16;

    typedef struct packed {
        logic              wr;
        logic              inc;
        logic [1:0]        fn;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
    } cmd_t;

    typedef enum logic [2:0] {
        ST_CMD, ST_WDATA, ST_RDATA, ST_STAT, ST_DONE
    } eng_st_e;

    function automatic logic [WORD_W-1:0] halfswap(input logic [WORD_W-1:0] x);
        return {x[WORD_W/2-1:0], x[WORD_W-1:WORD_W/2]};
    endfunction

endpackage

// File: rtl/gspi_sync.sv
module gspi_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic mosi_i,
    input  logic csn_i,
    output logic rise,
    output logic fall,
    output logic mosi_s,
    output logic cs_act
);
    localparam int unsigned N = (STAGES < 2) ? 2 : STAGES;

    typedef struct packed {
        logic [N-1:0] sclk;
        logic [N-1:0] mosi;
        logic [N-1:0] csn;
        logic         last;
    } sync_t;

    sync_t d, q;

    always_comb begin
        d      = q;
        d.sclk = {q.sclk[N-2:0], sclk_i};
        d.mosi = {q.mosi[N-2:0], mosi_i};
        d.csn  = {q.csn[N-2:0], csn_i};
        d.last = q.sclk[N-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.csn  <= '1;
        end else begin
            q <= d;
        end
    end

    assign rise   = q.sclk[N-1] & ~q.last;
    assign fall   = ~q.sclk[N-1] & q.last;
    assign mosi_s = q.mosi[N-1];
    assign cs_act = ~q.csn[N-1];

endmodule

// File: rtl/gspi_regs.sv
module gspi_regs
    import gspi_pkg::*;
#(
    parameter logic [WORD_W-1:0] TEST_SIG = 32'hFEEDBEAD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_fixed,
    input  logic [3:0]        wr_be,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_fixed,
    output logic [WORD_W-1:0] rd_word,
    input  logic [INT_W-1:0]  int_src,
    input  logic [8:0]        dev_status,
    output logic [WORD_W-1:0] status_word,
    output logic              word16,
    output logic              stat_en,
    output logic              irq
);
    localparam logic [7:0] BUSCTL_RST  = 8'h30;
    localparam logic [7:0] BUSCTL_MASK = 8'hB3;
    localparam logic [7:0] STSCTL_RST  = 8'h01;
    localparam logic [7:0] STSCTL_MASK = 8'h03;
    localparam logic [8:0] STATUS_MASK = 9'h12F;

    typedef struct packed {
        logic [7:0]        busctl;
        logic [7:0]        stsctl;
        logic [INT_W-1:0]  intr;
        logic [INT_W-1:0]  inten;
        logic [WORD_W-1:0] test;
    } regs_t;

    regs_t d, q;

    function automatic logic [7:0] byte_at(input logic [ADDR_W-1:0] a, input regs_t r,
                                           input logic [WORD_W-1:0] sw);
        logic [7:0] v;
        v = 8'h00;
        if (a[ADDR_W-1:5] == '0) begin
            case (a[4:0])
                5'h00: v = r.busctl;
                5'h02: v = r.stsctl;
                5'h04: v = r.intr[7:0];
                5'h05: v = r.intr[15:8];
                5'h06: v = r.inten[7:0];
                5'h07: v = r.inten[15:8];
                5'h08: v = sw[7:0];
                5'h09: v = sw[15:8];
                5'h0A: v = sw[23:16];
                5'h0B: v = sw[31:24];
                5'h14: v = TEST_SIG[7:0];
                5'h15: v = TEST_SIG[15:8];
                5'h16: v = TEST_SIG[23:16];
                5'h17: v = TEST_SIG[31:24];
                5'h18: v = r.test[7:0];
                5'h19: v = r.test[15:8];
                5'h1A: v = r.test[23:16];
                5'h1B: v = r.test[31:24];
                default: v = 8'h00;
            endcase
        end
        return v;
    endfunction

    assign status_word = {{(WORD_W-9){1'b0}}, dev_status & STATUS_MASK};

    always_comb begin
        for (int k = 0; k < 4; k++) begin
            rd_word[8*k +: 8] = byte_at(rd_fixed ? rd_addr : rd_addr + ADDR_W'(k), q, status_word);
        end
    end

    always_comb begin
        logic [ADDR_W-1:0] a;
        logic [7:0]        b;
        d = q;
        for (int k = 0; k < 4; k++) begin
            a = wr_fixed ? wr_addr : wr_addr + ADDR_W'(k);
            b = wr_data[8*k +: 8];
            if (wr_en && wr_be[k] && (a[ADDR_W-1:5] == '0)) begin
                case (a[4:0])
                    5'h00: d.busctl      = b & BUSCTL_MASK;
                    5'h02: d.stsctl      = b & STSCTL_MASK;
                    5'h04: d.intr[7:0]   = d.intr[7:0] & ~b;
                    5'h05: d.intr[15:8]  = d.intr[15:8] & ~b;
                    5'h06: d.inten[7:0]  = b;
                    5'h07: d.inten[15:8] = b;
                    5'h18: d.test[7:0]   = b;
                    5'h19: d.test[15:8]  = b;
                    5'h1A: d.test[23:16] = b;
                    5'h1B: d.test[31:24] = b;
                    default: ;
                endcase
            end
        end
        d.intr = d.intr | int_src;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.busctl <= BUSCTL_RST;
            q.stsctl <= STSCTL_RST;
        end else begin
            q <= d;
        end
    end

    assign word16  = ~q.busctl[0];
    assign stat_en = q.stsctl[0];
    assign irq     = q.busctl[5] ? (|(q.intr & q.inten)) : ~(|(q.intr & q.inten));

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (int_src != '0) |=> ((q.intr & $past(int_src)) == $past(int_src))); // R9
    AST_CFG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(q.busctl) && $stable(q.stsctl) && $stable(q.test))); // R3

endmodule

// File: rtl/gspi_engine.sv
module gspi_engine
    import gspi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise,
    input  logic              fall,
    input  logic              mosi,
    input  logic              cs_act,
    input  logic              word16_live,
    input  logic              stat_en_live,
    input  logic [WORD_W-1:0] rd_word,
    input  logic [WORD_W-1:0] status_word,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              wr_fixed,
    output logic [3:0]        wr_be,
    output logic [WORD_W-1:0] wr_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              rd_fixed,
    output logic              req_valid,
    output logic              req_write,
    output logic [1:0]        req_func,
    output logic [ADDR_W-1:0] req_addr,
    output logic [LEN_W-1:0]  req_len,
    output logic [WORD_W-1:0] req_wdata,
    input  logic [WORD_W-1:0] req_rdata,
    output logic              miso
);
    typedef struct packed {
        eng_st_e           st;
        logic [WORD_W-1:0] sh;
        logic [4:0]        bitcnt;
        logic              w16;
        logic              sten;
        logic              inc;
        logic [1:0]        fn;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
        logic [LEN_W-1:0]  rem;
        logic              miso;
    } eng_t;

    eng_t d, q;

    logic [WORD_W-1:0] wire_in, data_in;
    cmd_t              cmd_c;
    logic              mode16, sten_now, last_bit, commit, fetch;
    logic [1:0]        fetch_fn;
    logic [ADDR_W-1:0] fetch_addr, next_addr;
    logic              fetch_inc;
    logic [LEN_W-1:0]  rem_after;

    // decode and request side: depends only on registered state and line inputs
    always_comb begin
        wire_in    = {q.sh[WORD_W-2:0], mosi};
        cmd_c      = cmd_t'(word16_live ? halfswap(wire_in) : wire_in);
        mode16     = (q.st == ST_CMD) ? word16_live : q.w16;
        sten_now   = (q.st == ST_CMD) ? stat_en_live : q.sten;
        data_in    = mode16 ? halfswap(wire_in) : wire_in;
        rem_after  = (q.rem > LEN_W'(4)) ? q.rem - LEN_W'(4) : '0;
        next_addr  = q.inc ? q.addr + ADDR_W'(4) : q.addr;
        last_bit   = cs_act && rise && (q.bitcnt == 5'd31);
        commit     = last_bit && (q.st == ST_WDATA);
        fetch      = last_bit && (((q.st == ST_CMD) && !cmd_c.wr && (cmd_c.len != '0)) ||
                                  ((q.st == ST_RDATA) && (rem_after != '0)));
        fetch_fn   = (q.st == ST_CMD) ? cmd_c.fn   : q.fn;
        fetch_addr = (q.st == ST_CMD) ? cmd_c.addr : next_addr;
        fetch_inc  = (q.st == ST_CMD) ? cmd_c.inc  : q.inc;
        for (int k = 0; k < 4; k++) begin
            wr_be[k] = (LEN_W'(k) < q.rem);
        end
        wr_en     = commit && (q.fn == 2'd0);
        wr_addr   = q.addr;
        wr_fixed  = ~q.inc;
        wr_data   = data_in;
        rd_addr   = fetch_addr;
        rd_fixed  = ~fetch_inc;
        req_valid = (commit && (q.fn != 2'd0)) || (fetch && (fetch_fn != 2'd0));
        req_write = commit;
        req_func  = commit ? q.fn : fetch_fn;
        req_addr  = commit ? q.addr : fetch_addr;
        req_len   = (q.st == ST_CMD) ? cmd_c.len : q.len;
        req_wdata = data_in;
    end

    // next-state side
    always_comb begin
        logic [WORD_W-1:0] word_out;
        logic              go_tail;
        d        = q;
        go_tail  = 1'b0;
        word_out = (fetch_fn == 2'd0) ? rd_word : req_rdata;
        if (!cs_act) begin
            d.st     = ST_CMD;
            d.bitcnt = '0;
            d.sh     = '0;
            d.miso   = 1'b0;
        end else if (rise) begin
            d.bitcnt = q.bitcnt + 5'd1;
            case (q.st)
                ST_CMD: begin
                    d.sh = wire_in;
                    if (q.bitcnt == 5'd31) begin
                        d.inc  = cmd_c.inc;
                        d.fn   = cmd_c.fn;
                        d.addr = cmd_c.addr;
                        d.len  = cmd_c.len;
                        d.rem  = cmd_c.len;
                        d.w16  = word16_live;
                        d.sten = stat_en_live;
                        if (cmd_c.len == '0) go_tail = 1'b1;
                        else d.st = cmd_c.wr ? ST_WDATA : ST_RDATA;
                    end
                end
                ST_WDATA: begin
                    d.sh = wire_in;
                    if (q.bitcnt == 5'd31) begin
                        d.rem   = rem_after;
                        d.addr  = next_addr;
                        go_tail = (rem_after == '0);
                    end
                end
                ST_RDATA: begin
                    if (q.bitcnt == 5'd31) begin
                        d.rem   = rem_after;
                        d.addr  = next_addr;
                        go_tail = (rem_after == '0);
                    end
                end
                ST_STAT: if (q.bitcnt == 5'd31) d.st = ST_DONE;
                default: ;
            endcase
            if (fetch) d.sh = mode16 ? halfswap(word_out) : word_out;
            if (go_tail) begin
                d.st = sten_now ? ST_STAT : ST_DONE;
                d.sh = mode16 ? halfswap(status_word) : status_word;
            end
        end else if (fall) begin
            if ((q.st == ST_RDATA) || (q.st == ST_STAT)) begin
                d.miso = q.sh[WORD_W-1];
                d.sh   = {q.sh[WORD_W-2:0], 1'b0};
            end else begin
                d.miso = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_CMD;
        end else begin
            q <= d;
        end
    end

    assign miso = q.miso;

    AST_ABORT_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |-> !(wr_en || req_valid)); // R11
    AST_REQ_NOT_F0: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_func != 2'd0)); // R12
    AST_DATA_HAS_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.st == ST_WDATA) || (q.st == ST_RDATA)) |-> (q.rem != '0)); // R7

endmodule

// File: rtl/gspi_slave.sv
module gspi_slave
    import gspi_pkg::*;
#(
    parameter int unsigned       SYNC_STAGES = 2,
    parameter logic [WORD_W-1:0] TEST_SIG    = 32'hFEEDBEAD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_mosi,
    input  logic              spi_cs_n,
    output logic              spi_miso,
    output logic              irq,
    input  logic [INT_W-1:0]  int_src,
    input  logic [8:0]        dev_status,
    output logic              req_valid,
    output logic              req_write,
    output logic [1:0]        req_func,
    output logic [ADDR_W-1:0] req_addr,
    output logic [LEN_W-1:0]  req_len,
    output logic [WORD_W-1:0] req_wdata,
    input  logic [WORD_W-1:0] req_rdata
);
    logic              rise, fall, mosi_s, cs_act;
    logic              wr_en, wr_fixed, rd_fixed, word16, stat_en;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [3:0]        wr_be;
    logic [WORD_W-1:0] wr_data, rd_word, status_word;

    gspi_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .sclk_i(spi_sclk), .mosi_i(spi_mosi), .csn_i(spi_cs_n),
        .rise(rise), .fall(fall), .mosi_s(mosi_s), .cs_act(cs_act)
    );

    gspi_regs #(.TEST_SIG(TEST_SIG)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_fixed(wr_fixed),
        .wr_be(wr_be), .wr_data(wr_data), .rd_addr(rd_addr), .rd_fixed(rd_fixed),
        .rd_word(rd_word), .int_src(int_src), .dev_status(dev_status),
        .status_word(status_word), .word16(word16), .stat_en(stat_en), .irq(irq)
    );

    gspi_engine u_engine (
        .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall), .mosi(mosi_s), .cs_act(cs_act),
        .word16_live(word16), .stat_en_live(stat_en), .rd_word(rd_word),
        .status_word(status_word), .wr_en(wr_en), .wr_addr(wr_addr), .wr_fixed(wr_fixed),
        .wr_be(wr_be), .wr_data(wr_data), .rd_addr(rd_addr), .rd_fixed(rd_fixed),
        .req_valid(req_valid), .req_write(req_write), .req_func(req_func),
        .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
        .req_rdata(req_rdata), .miso(spi_miso)
    );

endmodule

// File: tb/gspi_slave_bench.sv
`timescale 1ns/1ps
module gspi_slave_bench;
    localparam int HALF = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spi_sclk = 1'b0, spi_mosi = 1'b0, spi_cs_n = 1'b1;
    logic        spi_miso, irq;
    logic [15:0] int_src = '0;
    logic [8:0]  dev_status = 9'h1FF;
    logic        req_valid, req_write;
    logic [1:0]  req_func;
    logic [16:0] req_addr;
    logic [10:0] req_len;
    logic [31:0] req_wdata, req_rdata;

    always #2 clk = ~clk;

    assign req_rdata = {15'h0, req_addr} ^ 32'hC0DE_0000;

    gspi_slave u_gspi_slave (
        .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_cs_n(spi_cs_n), .spi_miso(spi_miso), .irq(irq), .int_src(int_src),
        .dev_status(dev_status), .req_valid(req_valid), .req_write(req_write),
        .req_func(req_func), .req_addr(req_addr), .req_len(req_len),
        .req_wdata(req_wdata), .req_rdata(req_rdata)
    );

    int checks = 0, failures = 0;
    bit done = 0;
    bit hw16 = 1;
    logic [31:0] tx [0:7];
    logic [31:0] rx [0:7];
    int          req_cnt = 0;
    logic [31:0] rq_addr [0:7];
    logic [31:0] rq_data [0:7];
    logic        rq_wr [0:7];
    logic [1:0]  rq_fn [0:7];
    logic [10:0] rq_len [0:7];

    always @(negedge clk) begin
        if (req_valid && req_cnt < 8) begin
            rq_addr[req_cnt] = {15'h0, req_addr};
            rq_data[req_cnt] = req_write ? req_wdata : req_rdata;
            rq_wr[req_cnt]   = req_write;
            rq_fn[req_cnt]   = req_func;
            rq_len[req_cnt]  = req_len;
            req_cnt++;
        end
    end

    function automatic logic [31:0] sw16(input logic [31:0] x);
        return {x[15:0], x[31:16]};
    endfunction
    function automatic logic [31:0] hconv(input logic [31:0] x);
        return hw16 ? sw16(x) : x;
    endfunction
    function automatic logic [31:0] mk_cmd(input bit wr, input bit inc, input logic [1:0] fn,
                                           input logic [16:0] a, input logic [10:0] len);
        return {wr, inc, fn, a, len};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic spi_bit(input logic b, output logic r);
        spi_mosi = b;
        repeat (HALF) @(negedge clk);
        r = spi_miso;
        spi_sclk = 1'b1;
        repeat (HALF) @(negedge clk);
        spi_sclk = 1'b0;
    endtask

    task automatic spi_bits(input logic [31:0] w, input int n, output logic [31:0] r);
        logic bt;
        r = '0;
        for (int i = 31; i > 31 - n; i--) begin
            spi_bit(w[i], bt);
            r[i] = bt;
        end
    endtask

    task automatic txn(input logic [31:0] cmd, input int nw);
        logic [31:0] raw;
        @(negedge clk);
        spi_cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        spi_bits(hconv(cmd), 32, raw);
        for (int i = 1; i <= nw; i++) begin
            spi_bits(hconv(tx[i]), 32, raw);
            rx[i] = hconv(raw);
        end
        repeat (HALF) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    task automatic wr32(input logic [16:0] a, input logic [31:0] v);
        tx[1] = v;
        txn(mk_cmd(1, 1, 2'd0, a, 11'd4), 2);
    endtask

    task automatic rd32(input logic [16:0] a, output logic [31:0] v);
        tx[1] = '0; tx[2] = '0;
        txn(mk_cmd(0, 1, 2'd0, a, 11'd4), 2);
        v = rx[1];
    endtask

    task automatic pulse_int(input logic [15:0] m);
        @(negedge clk); int_src = m;
        @(negedge clk); int_src = '0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R10 irq idle after reset", {31'b0, irq}, 32'd0);
        chk("R12 no request after reset", {31'b0, req_valid}, 32'd0);
        chk("R8 miso quiet after reset", {31'b0, spi_miso}, 32'd0);
    endtask

    task automatic t_mode16;
        logic [31:0] v;
        tx[1] = '0; tx[2] = '0;
        txn(mk_cmd(0, 1, 2'd0, 17'h14, 11'd4), 2);
        chk("R2 R4 signature in halfword-swapped mode", rx[1], 32'hFEEDBEAD);
        chk("R8 status word after read", rx[2], 32'h0000012F);
        rd32(17'h00, v);
        chk("R3 configuration reset value", v, 32'h00010030);
    endtask

    task automatic t_mode32;
        logic [31:0] v;
        tx[1] = 32'h00010031; tx[2] = '0;
        txn(mk_cmd(1, 1, 2'd0, 17'h00, 11'd4), 2);
        chk("R2 R8 status after mode write still swapped", rx[2], 32'h0000012F);
        hw16 = 0;
        rd32(17'h14, v);
        chk("R2 signature in 32-bit mode", v, 32'hFEEDBEAD);
        rd32(17'h00, v);
        chk("R3 configuration readback", v, 32'h00010031);
    endtask

    task automatic t_testreg;
        logic [31:0] v;
        wr32(17'h18, 32'hA5C31E70);
        chk("R8 status after write", rx[2], 32'h0000012F);
        rd32(17'h18, v);
        chk("R5 test register readback", v, 32'hA5C31E70);
        wr32(17'h14, 32'h0);
        rd32(17'h14, v);
        chk("R4 signature ignores write", v, 32'hFEEDBEAD);
    endtask

    task automatic t_fixed;
        tx[1] = 32'h11223344; tx[2] = '0;
        txn(mk_cmd(1, 0, 2'd0, 17'h18, 11'd4), 2);
        tx[1] = '0;
        txn(mk_cmd(0, 1, 2'd0, 17'h18, 11'd4), 2);
        chk("R6 fixed write keeps last byte", rx[1], 32'hA5C31E11);
        txn(mk_cmd(0, 0, 2'd0, 17'h18, 11'd4), 2);
        chk("R6 fixed read repeats one byte", rx[1], 32'h11111111);
    endtask

    task automatic t_len;
        logic [31:0] v;
        tx[1] = 32'hDEADBEEF; tx[2] = '0;
        txn(mk_cmd(1, 1, 2'd0, 17'h18, 11'd2), 2);
        rd32(17'h18, v);
        chk("R7 short write stores two bytes", v, 32'hA5C3BEEF);
        tx[1] = '0; tx[2] = '0; tx[3] = '0;
        txn(mk_cmd(0, 1, 2'd0, 17'h14, 11'd5), 3);
        chk("R7 R1 five-byte read word 0", rx[1], 32'hFEEDBEAD);
        chk("R7 five-byte read word 1", rx[2], 32'hA5C3BEEF);
        chk("R7 R8 status after two words", rx[3], 32'h0000012F);
    endtask

    task automatic t_abort;
        logic [31:0] raw;
        logic [31:0] v;
        @(negedge clk);
        spi_cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        spi_bits(mk_cmd(1, 1, 2'd0, 17'h18, 11'd4), 32, raw);
        spi_bits(32'h0BAD0BAD, 20, raw);
        spi_cs_n = 1'b1;
        repeat (10) @(negedge clk);
        rd32(17'h18, v);
        chk("R11 aborted write not committed", v, 32'hA5C3BEEF);
    endtask

    task automatic t_irq;
        logic [31:0] v;
        pulse_int(16'h0020);
        chk("R10 disabled bit keeps irq low", {31'b0, irq}, 32'd0);
        rd32(17'h04, v);
        chk("R9 interrupt bit set by source", v, 32'h00000020);
        wr32(17'h04, 32'h00200000);
        chk("R10 enabled pending raises irq", {31'b0, irq}, 32'd1);
        pulse_int(16'h4000);
        rd32(17'h04, v);
        chk("R9 second source accumulates", v, 32'h00204020);
        wr32(17'h04, 32'h00200020);
        rd32(17'h04, v);
        chk("R9 write-one clears only that bit", v, 32'h00204000);
        chk("R10 irq drops after clear", {31'b0, irq}, 32'd0);
    endtask

    task automatic t_pol;
        wr32(17'h00, 32'h00010011);
        chk("R10 active-low idle level", {31'b0, irq}, 32'd1);
        wr32(17'h00, 32'h00010031);
        chk("R10 active-high idle level", {31'b0, irq}, 32'd0);
    endtask

    task automatic t_func;
        int base;
        base = req_cnt;
        tx[1] = 32'hCAFE0001; tx[2] = 32'hCAFE0002; tx[3] = '0;
        txn(mk_cmd(1, 1, 2'd1, 17'h1000E, 11'd8), 3);
        chk("R12 two write requests", req_cnt - base, 32'd2);
        chk("R12 first write address", rq_addr[base], 32'h1000E);
        chk("R12 second write address advances", rq_addr[base+1], 32'h10012);
        chk("R12 second write data", rq_data[base+1], 32'hCAFE0002);
        chk("R1 write flag function and length",
            {rq_wr[base], 1'b0, rq_fn[base], 17'h0, rq_len[base]}, {1'b1, 1'b0, 2'd1, 17'h0, 11'd8});
        base = req_cnt;
        tx[1] = '0; tx[2] = '0; tx[3] = '0;
        txn(mk_cmd(0, 1, 2'd2, 17'h00100, 11'd8), 3);
        chk("R12 read word 0 from request port", rx[1], 32'hC0DE0100);
        chk("R12 read word 1 from request port", rx[2], 32'hC0DE0104);
        chk("R1 read request is a read on function 2",
            {rq_wr[base], rq_fn[base]}, {1'b0, 2'd2});
        txn(mk_cmd(0, 0, 2'd3, 17'h00200, 11'd8), 3);
        chk("R6 fixed read word 0", rx[1], 32'hC0DE0200);
        chk("R6 fixed read word 1 same address", rx[2], 32'hC0DE0200);
    endtask

    task automatic t_stat_off;
        tx[1] = 32'h0; tx[2] = '0;
        txn(mk_cmd(1, 1, 2'd0, 17'h02, 11'd1), 2);
        tx[1] = '0; tx[2] = '0;
        txn(mk_cmd(0, 1, 2'd0, 17'h14, 11'd4), 2);
        chk("R8 data still served", rx[1], 32'hFEEDBEAD);
        chk("R8 no status word when disabled", rx[2], 32'h0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset;
        t_mode16;
        t_mode32;
        t_testreg;
        t_fixed;
        t_len;
        t_abort;
        t_irq;
        t_pol;
        t_func;
        t_stat_off;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog all-requirements actual=hung expected=complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule